// File: doc/BRIEF.md
# Modem Status Change Detector

This block produces the 8-bit modem status word of a serial port. It watches four active-low modem lines (clear-to-send, data-set-ready, ring indicator, carrier detect). It reports their true, active-high levels in the upper nibble and one sticky change flag per line in the lower nibble. The external lines are asynchronous, so each passes through a two-flop synchronizer before any comparison is made.

A host reads the word through a plain register-bus read strobe. `stat_word` always shows the current word. A cycle in which `rd_stb` is high counts as a read, and the flags clear at the end of that cycle. A loopback control swaps the level sources from the pins to four modem-control outputs of the same port. That is how a driver self-tests the port without a cable. A single interrupt request combines the flags with an enable.

The read strobe is a single-cycle control pulse with no back-pressure. The word is valid every cycle, so no valid/ready pair is needed at the edge.

Top module: `mdm_status_unit`

## Requirements
- R1: While and directly after reset, `stat_word` is 0x00 and `irq` is 0, with all four pins held high (inactive).
- R2: Bits 4, 5, 6 and 7 of `stat_word` are the inverted levels of `cts_n`, `dsr_n`, `ri_n` and `dcd_n` in that order. A pin change appears in the word after the third rising clock edge that follows it.
- R3: Bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier detect) each set when their level changes in either direction. A pulse that returns to the old level before a read still leaves the flag set.
- R4: Bit 2 sets only when the ring level falls (pin `ri_n` going from low to high). The leading edge of a ring sets no flag.
- R5: A set flag stays set until a read, whatever the lines do meanwhile.
- R6: During a cycle with `rd_stb` high, `stat_word` shows the word as it stands. Bits 0 to 3 clear at the closing clock edge of that cycle.
- R7: If a change event lands on the same clock edge as a read clears the flags, the flag for that event is set after the edge.
- R8: With `loop_en` high, bits 4 to 7 follow `ctl_rts`, `ctl_dtr`, `ctl_out1` and `ctl_out2` one clock edge after they change, and the four pins have no effect on the word.
- R9: Entering or leaving loopback sets the change flags that the resulting source switch produces, under the same rules as R3 and R4.
- R10: `irq` is high exactly when any of bits 0 to 3 is set and `irq_en` is high. It follows `irq_en` without a clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| loop_en | input | 1 | Selects the internal modem-control sources |
| ctl_rts | input | 1 | Request-to-send control output, loopback source of bit 4 |
| ctl_dtr | input | 1 | Data-terminal-ready control output, loopback source of bit 5 |
| ctl_out1 | input | 1 | User output 1, loopback source of bit 6 |
| ctl_out2 | input | 1 | User output 2, loopback source of bit 7 |
| irq_en | input | 1 | Modem-status interrupt enable |
| rd_stb | input | 1 | Read strobe; clears the change flags at its closing edge |
| stat_word | output | 8 | Status word: levels in [7:4], change flags in [3:0] |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that `loop_en`, `irq_en`, `rd_stb` and the four control inputs are synchronous to `clk`. The pins may be asynchronous. The loopback property also assumes that `loop_en` has been steady for a cycle before it compares levels with the control inputs. The stimulus changes every input one time unit after a rising edge and holds it for whole cycles. Pin pulses last at least two cycles, so the synchronizer never sees a level shorter than a clock period.

// File: rtl/mdm_status_pkg.sv
package mdm_status_pkg;

  localparam int LINE_CNT = 4;

  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;

  typedef enum logic [1:0] {
    TRIG_ANY  = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_RISE = 2'd2
  } trig_kind_e;

  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } line_vec_t;

  // Ring reports the end of a ring (level falling); all others report any change.
  function automatic trig_kind_e trig_for(input int idx);
    return (idx == IDX_RI) ? TRIG_FALL : TRIG_ANY;
  endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int         WIDTH     = 4,
  parameter int         STAGES    = 2,
  parameter logic [0:0] RESET_BIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= {WIDTH{RESET_BIT}};
    end else begin
      chain[0] <= d_async;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/mdm_source_sel.sv
module mdm_source_sel
  import mdm_status_pkg::*;
(
  input  line_vec_t pin_n_sync,
  input  line_vec_t ctl_lvl,
  input  logic      loop_en,
  output line_vec_t lvl_sel
);

  // Pins are active low: invert them. Control outputs are already active high.
  always_comb begin
    if (loop_en) lvl_sel = ctl_lvl;
    else         lvl_sel = ~pin_n_sync;
  end

endmodule

// File: rtl/mdm_delta_cell.sv
module mdm_delta_cell
  import mdm_status_pkg::*;
#(
  parameter trig_kind_e KIND = TRIG_ANY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  input  logic clr,
  output logic lvl_q,
  output logic evt,
  output logic flag_q
);

  generate
    if (KIND == TRIG_FALL) begin : g_fall
      assign evt = lvl_q & ~lvl_in;
    end else if (KIND == TRIG_RISE) begin : g_rise
      assign evt = ~lvl_q & lvl_in;
    end else begin : g_any
      assign evt = lvl_q ^ lvl_in;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_in;
      // A new event wins over a clear on the same edge.
      flag_q <= (flag_q & ~clr) | evt;
    end
  end

endmodule

// File: rtl/mdm_status_unit.sv
module mdm_status_unit
  import mdm_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  input  logic       loop_en,
  input  logic       ctl_rts,
  input  logic       ctl_dtr,
  input  logic       ctl_out1,
  input  logic       ctl_out2,
  input  logic       irq_en,
  input  logic       rd_stb,
  output logic [7:0] stat_word,
  output logic       irq
);

  line_vec_t pin_n_raw, pin_n_sync, ctl_lvl, lvl_sel;
  logic [LINE_CNT-1:0] lvl_vec, lvl_q, line_evt, flag_q;

  assign pin_n_raw = '{dcd: dcd_n, ri: ri_n, dsr: dsr_n, cts: cts_n};
  assign ctl_lvl   = '{dcd: ctl_out2, ri: ctl_out1, dsr: ctl_dtr, cts: ctl_rts};

  mdm_sync #(
    .WIDTH    (LINE_CNT),
    .STAGES   (SYNC_STAGES),
    .RESET_BIT(1'b1)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(pin_n_raw),
    .q_sync (pin_n_sync)
  );

  mdm_source_sel u_sel (
    .pin_n_sync(pin_n_sync),
    .ctl_lvl   (ctl_lvl),
    .loop_en   (loop_en),
    .lvl_sel   (lvl_sel)
  );

  assign lvl_vec = lvl_sel;

  for (genvar i = 0; i < LINE_CNT; i++) begin : g_line
    mdm_delta_cell #(
      .KIND(trig_for(i))
    ) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_in(lvl_vec[i]),
      .clr   (rd_stb),
      .lvl_q (lvl_q[i]),
      .evt   (line_evt[i]),
      .flag_q(flag_q[i])
    );
  end

  assign stat_word = {lvl_q, flag_q};
  assign irq       = irq_en & (|flag_q);

endmodule

// File: rtl/mdm_status_chk.sv
module mdm_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stb,
  input logic       loop_en,
  input logic       ctl_rts,
  input logic       irq_en,
  input logic       irq,
  input logic [7:0] stat_word,
  input logic [3:0] line_evt
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((stat_word[3:0] & $past(stat_word[3:0])) == $past(stat_word[3:0])));

  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && line_evt == 4'h0) |=> (stat_word[3:0] == 4'h0));

  p_evt_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && line_evt[0]) |=> stat_word[0]);

  p_cts_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && stat_word[4] != $past(stat_word[4])) |-> stat_word[0]);

  p_ring_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(stat_word[6]) && !$past(stat_word[2])) |-> !stat_word[2]);

  p_loop_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && loop_en && $past(loop_en)) |-> (stat_word[4] == $past(ctl_rts)));

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (stat_word[3:0] != 4'h0));

endmodule

bind mdm_status_unit mdm_status_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_stb   (rd_stb),
  .loop_en  (loop_en),
  .ctl_rts  (ctl_rts),
  .irq_en   (irq_en),
  .irq      (irq),
  .stat_word(stat_word),
  .line_evt (line_evt)
);

// File: tb/mdm_status_unit_test.sv
module mdm_status_unit_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic loop_en = 1'b0, ctl_rts = 1'b0, ctl_dtr = 1'b0, ctl_out1 = 1'b0, ctl_out2 = 1'b0;
  logic irq_en = 1'b0, rd_stb = 1'b0;
  logic [7:0] stat_word;
  logic irq;

  typedef struct {
    logic [7:0] data;
    logic       irq;
    string      req;
  } item_t;

  item_t exp_q[$];
  logic  chk_req = 1'b0;
  int    n_cmp = 0;
  int    n_bad = 0;
  logic  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdm_status_unit uut (
    .clk(clk), .rst_n(rst_n),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .loop_en(loop_en), .ctl_rts(ctl_rts), .ctl_dtr(ctl_dtr),
    .ctl_out1(ctl_out1), .ctl_out2(ctl_out2),
    .irq_en(irq_en), .rd_stb(rd_stb),
    .stat_word(stat_word), .irq(irq)
  );

  // Monitor: samples on the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (chk_req) begin
      item_t it;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL %s: scoreboard empty", "monitor");
      end else begin
        it = exp_q.pop_front();
        n_cmp++;
        if (stat_word !== it.data || irq !== it.irq) begin
          n_bad++;
          $display("FAIL %s: word=%h irq=%b expected word=%h irq=%b",
                   it.req, stat_word, irq, it.data, it.irq);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Driver: pushes the expected item and raises the compare (and optional read) for one cycle.
  task automatic expect_word(input logic [7:0] d, input logic i, input logic do_rd, input string req);
    item_t it;
    it.data = d; it.irq = i; it.req = req;
    exp_q.push_back(it);
    chk_req = 1'b1;
    rd_stb  = do_rd;
    step(1);
    chk_req = 1'b0;
    rd_stb  = 1'b0;
  endtask

  initial begin
    step(3);
    expect_word(8'h00, 1'b0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    irq_en = 1'b1;
    step(3);
    expect_word(8'h00, 1'b0, 1'b0, "R1 after reset");

    cts_n = 1'b0; step(2);
    expect_word(8'h00, 1'b0, 1'b0, "R2 not yet visible");
    expect_word(8'h11, 1'b1, 1'b0, "R2 R3 cts fall");
    expect_word(8'h11, 1'b1, 1'b1, "R6 read returns word");
    expect_word(8'h10, 1'b0, 1'b0, "R6 flags cleared");

    dsr_n = 1'b0; step(3);
    expect_word(8'h32, 1'b1, 1'b1, "R3 dsr change");
    expect_word(8'h30, 1'b0, 1'b0, "R6 dsr cleared");

    ri_n = 1'b0; step(3);
    expect_word(8'h70, 1'b0, 1'b0, "R4 ring leading edge no flag");
    ri_n = 1'b1; step(3);
    expect_word(8'h34, 1'b1, 1'b1, "R4 ring trailing edge");

    dcd_n = 1'b0; step(3);
    expect_word(8'hB8, 1'b1, 1'b0, "R3 dcd change");
    cts_n = 1'b1; step(3);
    expect_word(8'hA9, 1'b1, 1'b1, "R5 R3 flags accumulate");
    expect_word(8'hA0, 1'b0, 1'b0, "R6 cleared");

    cts_n = 1'b0; step(2);
    cts_n = 1'b1; step(4);
    expect_word(8'hA1, 1'b1, 1'b1, "R3 R5 pulse leaves flag");
    expect_word(8'hA0, 1'b0, 1'b0, "R6 cleared after pulse");

    irq_en = 1'b0;
    dsr_n = 1'b1; step(3);
    expect_word(8'h82, 1'b0, 1'b0, "R10 enable low");
    irq_en = 1'b1;
    expect_word(8'h82, 1'b1, 1'b1, "R10 enable high");
    expect_word(8'h80, 1'b0, 1'b0, "R10 no flags");

    cts_n = 1'b0; step(2);
    expect_word(8'h80, 1'b0, 1'b1, "R7 read on event edge");
    expect_word(8'h91, 1'b1, 1'b0, "R7 event kept");
    expect_word(8'h91, 1'b1, 1'b1, "R7 read");

    loop_en = 1'b1; step(1);
    expect_word(8'h09, 1'b1, 1'b1, "R9 entering loopback");
    expect_word(8'h00, 1'b0, 1'b0, "R8 loopback all low");
    ctl_out1 = 1'b1; step(1);
    expect_word(8'h40, 1'b0, 1'b0, "R8 R4 out1 rises");
    ctl_out1 = 1'b0; step(1);
    expect_word(8'h04, 1'b1, 1'b1, "R8 R4 out1 falls");
    ctl_rts = 1'b1; step(1);
    expect_word(8'h11, 1'b1, 1'b0, "R8 rts");
    ctl_dtr = 1'b1; step(1);
    expect_word(8'h33, 1'b1, 1'b0, "R8 dtr");
    ctl_out2 = 1'b1; step(1);
    expect_word(8'hBB, 1'b1, 1'b1, "R8 out2");
    ri_n = 1'b0; dsr_n = 1'b0; step(4);
    dsr_n = 1'b1; step(4);
    expect_word(8'hB0, 1'b0, 1'b0, "R8 pins ignored");

    loop_en = 1'b0; step(1);
    expect_word(8'hD2, 1'b1, 1'b1, "R9 leaving loopback");
    expect_word(8'hD0, 1'b0, 1'b0, "R9 settled");

    step(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule